// File: doc/BRIEF.md
# Lockstep ROM Comparison Tester

This block checks a read-only memory against a second memory of the same depth and width that is known to hold correct content. After a start pulse, one binary counter walks through every address. The same address goes to both memories in the same cycle. One cycle later, when both memories have returned their words, a compare stage checks that the two words are equal. The tester does not need to know what the memories contain, because the expected word always comes from the good memory.

When the sweep ends, the tester gives a single verdict. A one-cycle `done` pulse marks the end of the sweep. `pass` tells whether every word matched. The first address that differed is held on the outputs together with both words read at that address, so that the fault can be located. A start pulse that arrives while a sweep is running has no effect.

Top module: `rom_cmp_tester`

## Requirements
- R1: After reset, `done`, `pass`, `rom_addr`, `fail_addr`, `fail_ref` and `fail_dut` are all zero.
- R2: When a `start` pulse is sampled while the tester is idle, `rom_addr` shows 0 in the next cycle. It then rises by one every cycle up to 2^ADDR_W-1, so each address is issued exactly once.
- R3: The two memories have one cycle of read latency. The words on `ref_data` and `dut_data` in a given cycle are compared against the address that was on `rom_addr` in the previous cycle.
- R4: `done` is high for exactly one cycle. If `start` is sampled at clock edge E0, `done` is visible after edge E(2^ADDR_W+1).
- R5: When `done` rises, `pass` is 1 only if every compared word pair was equal. Accepting a start clears `pass` to 0. At every other time `pass` holds its value.
- R6: The first mismatch latches its address into `fail_addr`, the good memory's word into `fail_ref` and the tested memory's word into `fail_dut`. Later mismatches in the same sweep do not change these outputs. Accepting a start clears all three to zero.
- R7: A `start` pulse while a sweep is running or draining is ignored. The address sequence, the latched failure and the timing of `done` are unchanged.
- R8: A mismatch at the last address, 2^ADDR_W-1, makes the verdict a fail in the same sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that begins a sweep when the tester is idle |
| rom_addr | output | ADDR_W | Address driven to both memories |
| ref_data | input | DATA_W | Read word from the known-good memory |
| dut_data | input | DATA_W | Read word from the memory under test |
| done | output | 1 | One-cycle pulse at the end of a sweep |
| pass | output | 1 | Verdict of the last sweep; 1 means every word matched |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_ref | output | DATA_W | Good memory's word at the first mismatch |
| fail_dut | output | DATA_W | Tested memory's word at the first mismatch |

## Verification
The final verdict and the compare of the last address happen in the same cycle. The verdict must therefore fold in the mismatch that is seen at that moment as well as the latched flag. The bench provokes this by corrupting only the top address of the tested memory, and expects `pass` low with `fail_addr` equal to 2^ADDR_W-1.

A second collision is a start that is sampled in the cycle the sweep ends. The bench provokes it by pulsing `start` just before the sweep finishes. It then judges the run by the exact timing of `done` and by the first failure it latched, both of which must be unchanged.

// File: rtl/rct_pkg.sv
package rct_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } rct_state_t;

  // Number of clock edges from the accepting edge to the edge that raises done.
  function automatic int unsigned sweep_edges(input int unsigned addr_w);
    return (32'd1 << addr_w) + 32'd1;
  endfunction

endpackage

// File: rtl/rct_addr_gen.sv
module rct_addr_gen #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              at_last
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr <= '0;
    else if (clear) addr <= '0;
    else if (step)  addr <= bump(addr);
  end

  assign at_last = (addr == LAST_ADDR);
endmodule

// File: rtl/rct_compare.sv
module rct_compare #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              issue,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] ref_word,
  input  logic [DATA_W-1:0] dut_word,
  output logic              cmp_valid,
  output logic              mismatch,
  output logic              fail_seen,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_ref,
  output logic [DATA_W-1:0] fail_dut
);
  logic [ADDR_W-1:0] addr_q;

  function automatic logic words_differ(input logic [DATA_W-1:0] a,
                                        input logic [DATA_W-1:0] b);
    return |(a ^ b);
  endfunction

  // Align the address with the data, which arrives one cycle later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_valid <= 1'b0;
      addr_q    <= '0;
    end else begin
      cmp_valid <= issue && !clear;
      addr_q    <= addr;
    end
  end

  assign mismatch = cmp_valid && words_differ(ref_word, dut_word);

  // Keep only the first mismatch of a sweep.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_seen <= 1'b0;
      fail_addr <= '0;
      fail_ref  <= '0;
      fail_dut  <= '0;
    end else if (clear) begin
      fail_seen <= 1'b0;
      fail_addr <= '0;
      fail_ref  <= '0;
      fail_dut  <= '0;
    end else if (mismatch && !fail_seen) begin
      fail_seen <= 1'b1;
      fail_addr <= addr_q;
      fail_ref  <= ref_word;
      fail_dut  <= dut_word;
    end
  end
endmodule

// File: rtl/rom_cmp_tester.sv
module rom_cmp_tester #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [DATA_W-1:0] ref_data,
  input  logic [DATA_W-1:0] dut_data,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_ref,
  output logic [DATA_W-1:0] fail_dut
);
  import rct_pkg::*;

  rct_state_t state;
  logic start_acc;
  logic issue;
  logic last_addr;
  logic cmp_valid;
  logic mismatch;
  logic fail_seen;
  logic sweep_end;

  assign start_acc = (state == ST_IDLE) && start;
  assign issue     = (state == ST_RUN);
  assign sweep_end = (state == ST_DRAIN);

  rct_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start_acc),
    .step    (issue),
    .addr    (rom_addr),
    .at_last (last_addr)
  );

  rct_compare #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_acc),
    .issue     (issue),
    .addr      (rom_addr),
    .ref_word  (ref_data),
    .dut_word  (dut_data),
    .cmp_valid (cmp_valid),
    .mismatch  (mismatch),
    .fail_seen (fail_seen),
    .fail_addr (fail_addr),
    .fail_ref  (fail_ref),
    .fail_dut  (fail_dut)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:  if (start)     state <= ST_RUN;
        ST_RUN:   if (last_addr) state <= ST_DRAIN;
        ST_DRAIN: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // The verdict includes the compare that happens in the drain cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      pass <= 1'b0;
    end else begin
      done <= sweep_end;
      if (start_acc)      pass <= 1'b0;
      else if (sweep_end) pass <= !(fail_seen || mismatch);
    end
  end
endmodule

// File: rtl/rct_checker.sv
module rct_checker #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] rom_addr,
  input logic              done,
  input logic              pass,
  input logic [ADDR_W-1:0] fail_addr,
  input logic              issue,
  input logic              last_addr,
  input logic              start_acc,
  input logic              cmp_valid,
  input logic              fail_seen
);
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !last_addr) |=> (issue && rom_addr == ADDR_W'($past(rom_addr) + 1)));

  a_r2_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (issue && rom_addr == '0));

  a_r3_compare_lags_issue: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |-> $past(issue));

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_pass_moves_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pass) |-> (done || $past(start_acc)));

  a_r6_first_fail_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_seen && !start_acc) |=> (fail_seen && $stable(fail_addr)));

  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && start && !last_addr) |=> (rom_addr != '0));
endmodule

bind rom_cmp_tester rct_checker #(.ADDR_W(ADDR_W)) u_rct_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .rom_addr  (rom_addr),
  .done      (done),
  .pass      (pass),
  .fail_addr (fail_addr),
  .issue     (issue),
  .last_addr (last_addr),
  .start_acc (start_acc),
  .cmp_valid (cmp_valid),
  .fail_seen (fail_seen)
);

// File: tb/rom_cmp_tester_bench.sv
module rom_cmp_tester_bench;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] rom_addr;
  logic [DATA_W-1:0] ref_data, dut_data;
  logic done, pass;
  logic [ADDR_W-1:0] fail_addr;
  logic [DATA_W-1:0] fail_ref, fail_dut;

  logic [DATA_W-1:0] ref_mem [DEPTH];
  logic [DATA_W-1:0] dut_mem [DEPTH];

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Both memories: registered read, one cycle of latency.
  always_ff @(posedge clk) begin
    ref_data <= ref_mem[rom_addr];
    dut_data <= dut_mem[rom_addr];
  end

  rom_cmp_tester #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom_cmp_tester (
    .clk(clk), .rst_n(rst_n), .start(start), .rom_addr(rom_addr),
    .ref_data(ref_data), .dut_data(dut_data), .done(done), .pass(pass),
    .fail_addr(fail_addr), .fail_ref(fail_ref), .fail_dut(fail_dut)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int first_bad();
    for (int i = 0; i < DEPTH; i++)
      if (ref_mem[i] != dut_mem[i]) return i;
    return -1;
  endfunction

  task automatic fill_random();
    logic [31:0] r;
    for (int i = 0; i < DEPTH; i++) begin
      r = $urandom;
      ref_mem[i] = r[DATA_W-1:0];
      dut_mem[i] = r[DATA_W-1:0];
    end
  endtask

  task automatic inject(input int a);
    logic [31:0] r;
    r = $urandom;
    dut_mem[a] = ref_mem[a] ^ (r[DATA_W-1:0] | 8'h01);
  endtask

  // restart_at: count at which an extra start pulse is driven, or -1 for none.
  task automatic run_sweep(input string tag, input int restart_at);
    int fb;
    int c;
    int addr_err;
    logic pass_seen;
    fb = first_bad();
    addr_err = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk({tag, " R5 pass cleared on start"}, {31'd0, pass}, 32'd0);
    chk({tag, " R6 fail_addr cleared on start"}, {26'd0, fail_addr}, 32'd0);
    c = 0;
    while (!done && c < DEPTH + 10) begin
      if (c < DEPTH && rom_addr != ADDR_W'(c)) addr_err++;
      if (c == restart_at) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      c++;
    end
    chk({tag, " R2 R7 address sequence"}, addr_err, 32'd0);
    chk({tag, " R4 R7 done timing"}, c, DEPTH + 1);
    chk({tag, " R5 R8 verdict"}, {31'd0, pass}, (fb < 0) ? 32'd1 : 32'd0);
    if (fb >= 0) begin
      chk({tag, " R3 R6 fail_addr"}, {26'd0, fail_addr}, fb);
      chk({tag, " R6 fail_ref"}, {24'd0, fail_ref}, {24'd0, ref_mem[fb]});
      chk({tag, " R6 fail_dut"}, {24'd0, fail_dut}, {24'd0, dut_mem[fb]});
    end
    pass_seen = pass;
    @(negedge clk);
    chk({tag, " R4 done one cycle"}, {31'd0, done}, 32'd0);
    repeat (3) @(negedge clk);
    chk({tag, " R5 pass held"}, {31'd0, pass}, {31'd0, pass_seen});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fill_random();
    repeat (3) @(negedge clk);
    chk("R1 done at reset", {31'd0, done}, 32'd0);
    chk("R1 pass at reset", {31'd0, pass}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rom_addr after reset", {26'd0, rom_addr}, 32'd0);
    chk("R1 fail_addr after reset", {26'd0, fail_addr}, 32'd0);
    chk("R1 fail_dut after reset", {24'd0, fail_dut}, 32'd0);

    run_sweep("clean", -1);

    inject(0);
    run_sweep("fault_at_0", -1);

    fill_random();
    inject(DEPTH - 1);
    run_sweep("fault_at_last", -1);

    fill_random();
    inject(9); inject(20); inject(50);
    run_sweep("multi_fault", -1);

    fill_random();
    inject(5); inject(40);
    run_sweep("restart_mid", 30);
    run_sweep("restart_end", DEPTH - 1);

    for (int k = 0; k < 4; k++) begin
      fill_random();
      for (int j = 0; j < k; j++) begin
        logic [31:0] r;
        r = $urandom;
        inject(int'(r[ADDR_W-1:0]));
      end
      run_sweep("random", -1);
    end

    fill_random();
    run_sweep("clean_again", -1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule